// File: doc/BRIEF.md
# Host Status Word and Read Handshake Tracker

This block holds a 32-bit status word that a host can read over its serial command link at any moment, with no fetch step in front of it. The command path feeds it event pulses: the receive queue is full, a commanded task has started or finished, a read has been requested, the data for a read is ready, the host has come to collect it, and a write command has executed with its tag. Error reports arrive with a category and a 12-bit code. Link faults also arrive as three dedicated pulses: queue overflow, a transaction cut short, and a transaction overrun. The software layer supplies the mode, emergency-shutdown and initialized levels.

Every status field is registered, so a level or pulse on an input shows in `status_o` one clock later. The read handshake keeps a small generation count. Each new read request advances the count, and a data-ready pulse is taken only when it carries the current count. A result that belongs to a superseded request is therefore dropped without any error. The error part keeps the latest code and sticky category flags. It also keeps the tag of the last executed write, and it writes tag 0 whenever an error has no trustworthy tag.

Top module: `host_status_word`

## Requirements
- R1: `status_o` is packed as follows. Bits 7:6 hold the mode (0 boot, 1 standby, 2 display). Bit 5 is emergency shutdown, bit 4 always reads 0, bit 3 is read data available, bit 2 is busy, bit 1 is task in progress and bit 0 is initialized. Bits 15:8 hold the tag. Bits 27:16 hold the error code. Bits 28, 29, 30 and 31 are the link, command, operational and self-test error flags. After reset the whole word is 0 and `pf_gen_o` is 0.
- R2: Bit 2 of the status word equals `rxfifo_full_i` from one clock earlier, and it clears one clock after the queue stops being full.
- R3: `task_start_i` sets bit 1 and `task_done_i` clears it. When both pulse in the same cycle, bit 1 ends up at 1.
- R4: Each `pf_req_i` advances `pf_gen_o` by 1, modulo 2^GEN_W. While a request is outstanding, a `pf_ready_i` pulse whose `pf_ready_gen_i` equals `pf_gen_o` sets bit 3 on the next clock.
- R5: A new `pf_req_i` clears bit 3 and drops the old data, and no error field changes. A ready pulse with a stale generation is ignored, and so is a ready pulse that arrives in the same cycle as a new request. A ready pulse with no request outstanding is ignored as well.
- R6: `rd_grant_o` equals `rd_act_i` while bit 3 is set, and a grant clears bit 3. An activate with no data available gives no grant and changes nothing. When an activate and a new request fall in the same cycle, the old data is granted first and the new request is then outstanding.
- R7: `cmd_exec_i` loads `cmd_tag_i` into the tag field, whether the command succeeded or failed.
- R8: `err_valid_i` loads `err_code_i` into the code field and sets the flag selected by `err_cat_i` (0 link, 1 command, 2 operational, 3 self-test). The tag field takes `err_tag_i` if `err_tag_vld_i` is high and 0 otherwise. This overrides a `cmd_exec_i` in the same cycle.
- R9: `rx_ovf_i`, `xfer_short_i` and `xfer_long_i` each set the link flag, load tag 0 and load their parameter codes OVF_CODE, SHORT_CODE and LONG_CODE. When several error sources fire together, the code is taken in the order `err_valid_i`, then overflow, then short, then long. The flags of all of them are set.
- R10: The category flags are sticky. `clr_err_i` zeroes the flags and the code and leaves the tag alone. An error that arrives in the same cycle as a clear is kept.
- R11: The mode, emergency-shutdown and initialized fields show `mode_i`, `estop_i` and `init_i` from one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Application/operating mode |
| init_i | input | 1 | Software ready level |
| estop_i | input | 1 | Emergency shutdown level |
| rxfifo_full_i | input | 1 | Receive queue full |
| task_start_i | input | 1 | Commanded task started |
| task_done_i | input | 1 | Commanded task finished |
| pf_req_i | input | 1 | New read request |
| pf_ready_i | input | 1 | Read data ready |
| pf_ready_gen_i | input | GEN_W | Generation of the ready data |
| rd_act_i | input | 1 | Host collects read data |
| cmd_exec_i | input | 1 | Write command executed |
| cmd_tag_i | input | TAG_W | Tag of executed command |
| err_valid_i | input | 1 | Error report |
| err_cat_i | input | 2 | Error category |
| err_code_i | input | CODE_W | Error code |
| err_tag_vld_i | input | 1 | Error tag is trustworthy |
| err_tag_i | input | TAG_W | Tag tied to the error |
| rx_ovf_i | input | 1 | Receive queue overflow |
| xfer_short_i | input | 1 | Transaction had too few clocks |
| xfer_long_i | input | 1 | Transaction had too many clocks |
| clr_err_i | input | 1 | Clear error flags and code |
| status_o | output | 12+TAG_W+CODE_W | Packed status word |
| pf_gen_o | output | GEN_W | Current request generation |
| rd_grant_o | output | 1 | Activate served with data |

## Verification
The bench builds the block with its defaults: an 8-bit tag, a 12-bit code and a 2-bit generation. The narrow generation count wraps after four requests, so wraparound is reached quickly, and stale ready pulses from exactly one generation back can be made at will. With these widths the bench can compare the whole word against its model on every clock. Directed sequences drive the same-cycle collisions: activate with request, ready with request, start with done, error with clear, and all error sources firing at once. A long random phase then mixes every event.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [1:0] {
    CAT_LINK = 2'd0,
    CAT_CMD  = 2'd1,
    CAT_OPER = 2'd2,
    CAT_BIST = 2'd3
  } err_cat_e;

  localparam int unsigned NUM_CAT  = 4;
  localparam int unsigned FLAGS_W  = 8;
endpackage

// File: rtl/hsw_level_flags.sv
module hsw_level_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       init_i,
  input  logic       estop_i,
  input  logic       rxfifo_full_i,
  input  logic       task_start_i,
  input  logic       task_done_i,
  output logic [1:0] mode_o,
  output logic       init_o,
  output logic       estop_o,
  output logic       busy_o,
  output logic       prog_o
);
  logic [1:0] mode_q;
  logic       init_q, estop_q, busy_q, prog_q, prog_d, prog_en;

  always_comb begin
    prog_en = task_start_i | task_done_i;
    prog_d  = task_start_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 2'd0;
      init_q  <= 1'b0;
      estop_q <= 1'b0;
      busy_q  <= 1'b0;
      prog_q  <= 1'b0;
    end else begin
      mode_q  <= mode_i;
      init_q  <= init_i;
      estop_q <= estop_i;
      busy_q  <= rxfifo_full_i;
      if (prog_en) prog_q <= prog_d;
    end
  end

  assign mode_o  = mode_q;
  assign init_o  = init_q;
  assign estop_o = estop_q;
  assign busy_o  = busy_q;
  assign prog_o  = prog_q;
endmodule

// File: rtl/hsw_read_hs.sv
module hsw_read_hs #(
  parameter int unsigned GEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pf_req_i,
  input  logic             pf_ready_i,
  input  logic [GEN_W-1:0] pf_ready_gen_i,
  input  logic             rd_act_i,
  output logic [GEN_W-1:0] gen_o,
  output logic             avail_o,
  output logic             grant_o
);
  logic [GEN_W-1:0] gen_q, gen_d;
  logic             pend_q, pend_d, avail_q, avail_d;
  logic             accept, grant, hs_en;

  always_comb begin
    grant  = rd_act_i & avail_q;
    accept = pf_ready_i & pend_q & ~pf_req_i & (pf_ready_gen_i == gen_q);
    gen_d   = gen_q;
    pend_d  = pend_q;
    avail_d = avail_q;
    if (pf_req_i) begin
      gen_d   = gen_q + GEN_W'(1);
      pend_d  = 1'b1;
      avail_d = 1'b0;
    end else if (accept) begin
      pend_d  = 1'b0;
      avail_d = 1'b1;
    end else if (grant) begin
      avail_d = 1'b0;
    end
    hs_en = pf_req_i | accept | grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q   <= '0;
      pend_q  <= 1'b0;
      avail_q <= 1'b0;
    end else if (hs_en) begin
      gen_q   <= gen_d;
      pend_q  <= pend_d;
      avail_q <= avail_d;
    end
  end

  assign gen_o   = gen_q;
  assign avail_o = avail_q;
  assign grant_o = grant;
endmodule

// File: rtl/hsw_err_latch.sv
module hsw_err_latch
  import hsw_pkg::*;
#(
  parameter int unsigned TAG_W      = 8,
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned OVF_CODE   = 'h101,
  parameter int unsigned SHORT_CODE = 'h102,
  parameter int unsigned LONG_CODE  = 'h103
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_exec_i,
  input  logic [TAG_W-1:0]  cmd_tag_i,
  input  logic              err_valid_i,
  input  err_cat_e          err_cat_i,
  input  logic [CODE_W-1:0] err_code_i,
  input  logic              err_tag_vld_i,
  input  logic [TAG_W-1:0]  err_tag_i,
  input  logic              rx_ovf_i,
  input  logic              xfer_short_i,
  input  logic              xfer_long_i,
  input  logic              clr_err_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [CODE_W-1:0] code_o,
  output logic [NUM_CAT-1:0] flags_o
);
  logic [TAG_W-1:0]   tag_q, tag_d;
  logic [CODE_W-1:0]  code_q, code_d, code_new;
  logic [NUM_CAT-1:0] flags_q, flags_d, set_v;
  logic               link_evt, new_hit, tag_en, err_en;

  always_comb begin
    link_evt = rx_ovf_i | xfer_short_i | xfer_long_i;
    new_hit  = err_valid_i | link_evt;

    set_v = '0;
    for (int c = 0; c < NUM_CAT; c++) begin
      if (err_valid_i && (int'(err_cat_i) == c)) set_v[c] = 1'b1;
    end
    if (link_evt) set_v[CAT_LINK] = 1'b1;

    if (err_valid_i)       code_new = err_code_i;
    else if (rx_ovf_i)     code_new = CODE_W'(OVF_CODE);
    else if (xfer_short_i) code_new = CODE_W'(SHORT_CODE);
    else                   code_new = CODE_W'(LONG_CODE);

    flags_d = (clr_err_i ? '0 : flags_q) | set_v;
    code_d  = new_hit ? code_new : (clr_err_i ? '0 : code_q);
    err_en  = new_hit | clr_err_i;

    if (new_hit) tag_d = (err_valid_i && err_tag_vld_i) ? err_tag_i : '0;
    else         tag_d = cmd_tag_i;
    tag_en = new_hit | cmd_exec_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= '0;
      code_q  <= '0;
      flags_q <= '0;
    end else begin
      if (tag_en) tag_q <= tag_d;
      if (err_en) begin
        code_q  <= code_d;
        flags_q <= flags_d;
      end
    end
  end

  assign tag_o   = tag_q;
  assign code_o  = code_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/host_status_word.sv
module host_status_word
  import hsw_pkg::*;
#(
  parameter int unsigned TAG_W      = 8,
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned GEN_W      = 2,
  parameter int unsigned OVF_CODE   = 'h101,
  parameter int unsigned SHORT_CODE = 'h102,
  parameter int unsigned LONG_CODE  = 'h103
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [1:0]                             mode_i,
  input  logic                                   init_i,
  input  logic                                   estop_i,
  input  logic                                   rxfifo_full_i,
  input  logic                                   task_start_i,
  input  logic                                   task_done_i,
  input  logic                                   pf_req_i,
  input  logic                                   pf_ready_i,
  input  logic [GEN_W-1:0]                       pf_ready_gen_i,
  input  logic                                   rd_act_i,
  input  logic                                   cmd_exec_i,
  input  logic [TAG_W-1:0]                       cmd_tag_i,
  input  logic                                   err_valid_i,
  input  logic [1:0]                             err_cat_i,
  input  logic [CODE_W-1:0]                      err_code_i,
  input  logic                                   err_tag_vld_i,
  input  logic [TAG_W-1:0]                       err_tag_i,
  input  logic                                   rx_ovf_i,
  input  logic                                   xfer_short_i,
  input  logic                                   xfer_long_i,
  input  logic                                   clr_err_i,
  output logic [FLAGS_W+TAG_W+CODE_W+NUM_CAT-1:0] status_o,
  output logic [GEN_W-1:0]                       pf_gen_o,
  output logic                                   rd_grant_o
);
  logic [1:0]         mode_w;
  logic               init_w, estop_w, busy_w, prog_w, avail_w;
  logic [TAG_W-1:0]   tag_w;
  logic [CODE_W-1:0]  code_w;
  logic [NUM_CAT-1:0] flags_w;
  logic [FLAGS_W-1:0] byte_flags;

  hsw_level_flags u_lvl (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .init_i        (init_i),
    .estop_i       (estop_i),
    .rxfifo_full_i (rxfifo_full_i),
    .task_start_i  (task_start_i),
    .task_done_i   (task_done_i),
    .mode_o        (mode_w),
    .init_o        (init_w),
    .estop_o       (estop_w),
    .busy_o        (busy_w),
    .prog_o        (prog_w)
  );

  hsw_read_hs #(.GEN_W(GEN_W)) u_rd (
    .clk            (clk),
    .rst_n          (rst_n),
    .pf_req_i       (pf_req_i),
    .pf_ready_i     (pf_ready_i),
    .pf_ready_gen_i (pf_ready_gen_i),
    .rd_act_i       (rd_act_i),
    .gen_o          (pf_gen_o),
    .avail_o        (avail_w),
    .grant_o        (rd_grant_o)
  );

  hsw_err_latch #(
    .TAG_W(TAG_W), .CODE_W(CODE_W),
    .OVF_CODE(OVF_CODE), .SHORT_CODE(SHORT_CODE), .LONG_CODE(LONG_CODE)
  ) u_err (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_exec_i    (cmd_exec_i),
    .cmd_tag_i     (cmd_tag_i),
    .err_valid_i   (err_valid_i),
    .err_cat_i     (err_cat_e'(err_cat_i)),
    .err_code_i    (err_code_i),
    .err_tag_vld_i (err_tag_vld_i),
    .err_tag_i     (err_tag_i),
    .rx_ovf_i      (rx_ovf_i),
    .xfer_short_i  (xfer_short_i),
    .xfer_long_i   (xfer_long_i),
    .clr_err_i     (clr_err_i),
    .tag_o         (tag_w),
    .code_o        (code_w),
    .flags_o       (flags_w)
  );

  always_comb begin
    byte_flags = {mode_w, estop_w, 1'b0, avail_w, busy_w, prog_w, init_w};
    status_o   = {flags_w, code_w, tag_w, byte_flags};
  end
endmodule

// File: rtl/hsw_checker.sv
module hsw_checker #(
  parameter int unsigned SW    = 32,
  parameter int unsigned GEN_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rxfifo_full_i,
  input logic             task_start_i,
  input logic             task_done_i,
  input logic             pf_req_i,
  input logic             err_valid_i,
  input logic             rx_ovf_i,
  input logic             xfer_short_i,
  input logic             xfer_long_i,
  input logic             clr_err_i,
  input logic [SW-1:0]    status_o,
  input logic [GEN_W-1:0] pf_gen_o,
  input logic             rd_grant_o
);
  logic any_err;
  assign any_err = err_valid_i | rx_ovf_i | xfer_short_i | xfer_long_i;

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[4] == 1'b0);
  a_r2_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rxfifo_full_i |=> status_o[2]);
  a_r2_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !rxfifo_full_i |=> !status_o[2]);
  a_r3_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    task_start_i |=> status_o[1]);
  a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (task_done_i && !task_start_i) |=> !status_o[1]);
  a_r4_gen_step: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req_i |=> (pf_gen_o == GEN_W'($past(pf_gen_o) + 1'b1)));
  a_r4_gen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_req_i |=> $stable(pf_gen_o));
  a_r5_request_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req_i |=> !status_o[3]);
  a_r6_grant_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant_o |=> !status_o[3]);
  a_r6_grant_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[3] |-> !rd_grant_o);
  a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err_i && !any_err) |=> (status_o[SW-1:16] == '0));
  a_r10_sticky_link: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[SW-4] && !clr_err_i) |=> status_o[SW-4]);
endmodule

bind host_status_word hsw_checker #(
  .SW(FLAGS_W+TAG_W+CODE_W+NUM_CAT), .GEN_W(GEN_W)
) u_hsw_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .rxfifo_full_i (rxfifo_full_i),
  .task_start_i  (task_start_i),
  .task_done_i   (task_done_i),
  .pf_req_i      (pf_req_i),
  .err_valid_i   (err_valid_i),
  .rx_ovf_i      (rx_ovf_i),
  .xfer_short_i  (xfer_short_i),
  .xfer_long_i   (xfer_long_i),
  .clr_err_i     (clr_err_i),
  .status_o      (status_o),
  .pf_gen_o      (pf_gen_o),
  .rd_grant_o    (rd_grant_o)
);

// File: tb/host_status_word_bench.sv
`timescale 1ns/1ps
module host_status_word_bench;
  localparam int OVF = 'h101, SHRT = 'h102, LNG = 'h103;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic        init_i, estop_i, rxfifo_full_i, task_start_i, task_done_i;
  logic        pf_req_i, pf_ready_i, rd_act_i, cmd_exec_i;
  logic [1:0]  pf_ready_gen_i;
  logic [7:0]  cmd_tag_i, err_tag_i;
  logic        err_valid_i, err_tag_vld_i, rx_ovf_i, xfer_short_i, xfer_long_i, clr_err_i;
  logic [1:0]  err_cat_i;
  logic [11:0] err_code_i;
  logic [31:0] status_o;
  logic [1:0]  pf_gen_o;
  logic        rd_grant_o;

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit chk_en = 0, done = 0;

  int m_mode, m_init, m_estop, m_busy, m_prog, m_gen, m_pend, m_avail, m_tag, m_code;
  bit [3:0] m_flags;

  always #2.5 clk = ~clk;

  host_status_word u_host_status_word (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .init_i(init_i), .estop_i(estop_i),
    .rxfifo_full_i(rxfifo_full_i), .task_start_i(task_start_i), .task_done_i(task_done_i),
    .pf_req_i(pf_req_i), .pf_ready_i(pf_ready_i), .pf_ready_gen_i(pf_ready_gen_i),
    .rd_act_i(rd_act_i), .cmd_exec_i(cmd_exec_i), .cmd_tag_i(cmd_tag_i),
    .err_valid_i(err_valid_i), .err_cat_i(err_cat_i), .err_code_i(err_code_i),
    .err_tag_vld_i(err_tag_vld_i), .err_tag_i(err_tag_i), .rx_ovf_i(rx_ovf_i),
    .xfer_short_i(xfer_short_i), .xfer_long_i(xfer_long_i), .clr_err_i(clr_err_i),
    .status_o(status_o), .pf_gen_o(pf_gen_o), .rd_grant_o(rd_grant_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference, updated at each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_init = 0; m_estop = 0; m_busy = 0; m_prog = 0;
      m_gen = 0; m_pend = 0; m_avail = 0; m_tag = 0; m_code = 0; m_flags = 0;
    end else begin
      int new_code;
      bit hit;
      m_mode = mode_i; m_init = init_i; m_estop = estop_i; m_busy = rxfifo_full_i;
      if (task_start_i) m_prog = 1;
      else if (task_done_i) m_prog = 0;
      if (pf_req_i) begin
        m_gen = (m_gen + 1) % 4; m_pend = 1; m_avail = 0;
      end else if (pf_ready_i && m_pend == 1 && int'(pf_ready_gen_i) == m_gen) begin
        m_pend = 0; m_avail = 1;
      end else if (rd_act_i && m_avail == 1) begin
        m_avail = 0;
      end
      hit = err_valid_i | rx_ovf_i | xfer_short_i | xfer_long_i;
      if (clr_err_i) begin m_flags = 0; m_code = 0; end
      if (xfer_long_i)  begin m_flags[0] = 1; new_code = LNG; end
      if (xfer_short_i) begin m_flags[0] = 1; new_code = SHRT; end
      if (rx_ovf_i)     begin m_flags[0] = 1; new_code = OVF; end
      if (err_valid_i)  begin m_flags[err_cat_i] = 1; new_code = err_code_i; end
      if (hit) begin
        m_code = new_code;
        m_tag = (err_valid_i && err_tag_vld_i) ? int'(err_tag_i) : 0;
      end else if (cmd_exec_i) m_tag = cmd_tag_i;
    end
  end

  // Compare on every clock, away from the rising edge.
  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      chk("R11", "mode", status_o[7:6], m_mode);
      chk("R11", "estop", status_o[5], m_estop);
      chk("R11", "init", status_o[0], m_init);
      chk("R1", "reserved", status_o[4], 0);
      chk("R2", "busy", status_o[2], m_busy);
      chk("R3", "in-progress", status_o[1], m_prog);
      chk("R5", "avail", status_o[3], m_avail);
      chk("R4", "gen", pf_gen_o, m_gen);
      chk("R7", "tag", status_o[15:8], m_tag);
      chk("R8", "code", status_o[27:16], m_code);
      chk("R10", "flags", status_o[31:28], m_flags);
      #1;
      chk("R6", "grant", rd_grant_o, (rd_act_i && m_avail == 1) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d expected<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic quiet();
    task_start_i = 0; task_done_i = 0; pf_req_i = 0; pf_ready_i = 0; rd_act_i = 0;
    cmd_exec_i = 0; err_valid_i = 0; rx_ovf_i = 0; xfer_short_i = 0; xfer_long_i = 0;
    clr_err_i = 0; err_tag_vld_i = 0;
  endtask

  task automatic step();
    @(negedge clk); quiet();
  endtask

  initial begin
    rst_n = 0; mode_i = 0; init_i = 0; estop_i = 0; rxfifo_full_i = 0;
    pf_ready_gen_i = 0; cmd_tag_i = 0; err_tag_i = 0; err_cat_i = 0; err_code_i = 0;
    quiet();
    repeat (3) @(negedge clk);
    chk("R1", "reset word", status_o, 0);
    chk("R1", "reset gen", pf_gen_o, 0);
    rst_n = 1; chk_en = 1;

    // R11 levels and R2 busy
    step(); mode_i = 2; init_i = 1; estop_i = 1; rxfifo_full_i = 1;
    step(); chk("R2", "busy set", status_o[2], 1); rxfifo_full_i = 0;
    step(); chk("R2", "busy cleared", status_o[2], 0);
    chk("R11", "display mode", status_o[7:6], 2);
    // R3 start/done, then both together
    step(); task_start_i = 1;
    step(); task_done_i = 1;
    step(); chk("R3", "done clears", status_o[1], 0); task_start_i = 1; task_done_i = 1;
    step(); chk("R3", "start wins", status_o[1], 1);
    // R4 request then ready
    step(); pf_req_i = 1;
    step(); pf_ready_i = 1; pf_ready_gen_i = 1;
    step(); chk("R4", "data available", status_o[3], 1);
    // R6 activate consumes
    rd_act_i = 1; #1; chk("R6", "grant", rd_grant_o, 1);
    step(); chk("R6", "consumed", status_o[3], 0); rd_act_i = 1;
    #1; chk("R6", "no grant when empty", rd_grant_o, 0);
    // R5 stale replacement
    step(); pf_req_i = 1;
    step(); pf_ready_i = 1; pf_ready_gen_i = 2;
    step(); pf_req_i = 1;
    step(); chk("R5", "replaced, flag low", status_o[3], 0);
    chk("R5", "no error on replace", status_o[31:16], 0);
    pf_ready_i = 1; pf_ready_gen_i = 2;
    step(); chk("R5", "stale gen ignored", status_o[3], 0);
    pf_req_i = 1; pf_ready_i = 1; pf_ready_gen_i = 3;
    step(); chk("R5", "ready with request ignored", status_o[3], 0);
    chk("R4", "gen wrapped", pf_gen_o, 0);
    pf_ready_i = 1; pf_ready_gen_i = 0;
    step(); rd_act_i = 1; pf_req_i = 1;
    #1; chk("R6", "activate before new request", rd_grant_o, 1);
    step(); chk("R6", "new request pending", status_o[3], 0);
    pf_ready_i = 1; pf_ready_gen_i = 1;
    step(); chk("R6", "re-armed", status_o[3], 1);
    // R7 tag and R8 errors
    cmd_exec_i = 1; cmd_tag_i = 8'h5A;
    step(); chk("R7", "tag", status_o[15:8], 'h5A);
    err_valid_i = 1; err_cat_i = 1; err_code_i = 12'h3C4; err_tag_vld_i = 1; err_tag_i = 8'h77;
    cmd_exec_i = 1; cmd_tag_i = 8'h11;
    step(); chk("R8", "error tag wins", status_o[15:8], 'h77);
    chk("R8", "cmd flag", status_o[29], 1);
    err_valid_i = 1; err_cat_i = 3; err_code_i = 12'h0F2;
    step(); chk("R8", "null tag", status_o[15:8], 0);
    chk("R8", "latest code", status_o[27:16], 'h0F2);
    chk("R10", "sticky flags", status_o[31:28], 4'b1010);
    // R9 link faults and priority
    rx_ovf_i = 1; xfer_short_i = 1; xfer_long_i = 1;
    step(); chk("R9", "overflow code first", status_o[27:16], OVF);
    chk("R9", "link flag", status_o[28], 1);
    xfer_short_i = 1; xfer_long_i = 1;
    step(); chk("R9", "short code", status_o[27:16], SHRT);
    xfer_long_i = 1;
    step(); chk("R9", "long code", status_o[27:16], LNG);
    // R10 clear
    clr_err_i = 1;
    step(); chk("R10", "cleared", status_o[31:16], 0);
    chk("R10", "tag kept", status_o[15:8], 0);
    clr_err_i = 1; err_valid_i = 1; err_cat_i = 2; err_code_i = 12'h9;
    step(); chk("R10", "error beside clear kept", status_o[31:16], 16'h4009);

    // Mixed random phase
    for (int i = 0; i < 3000; i++) begin
      step();
      mode_i = 2'($urandom % 3); init_i = 1'($urandom); estop_i = ($urandom % 8) == 0;
      rxfifo_full_i = ($urandom % 4) == 0;
      task_start_i = ($urandom % 6) == 0; task_done_i = ($urandom % 6) == 0;
      pf_req_i = ($urandom % 7) == 0; pf_ready_i = ($urandom % 3) == 0;
      pf_ready_gen_i = 2'((($urandom % 3) == 0) ? m_gen - 1 : m_gen);
      rd_act_i = ($urandom % 3) == 0;
      cmd_exec_i = ($urandom % 4) == 0; cmd_tag_i = 8'($urandom);
      err_valid_i = ($urandom % 9) == 0; err_cat_i = 2'($urandom);
      err_code_i = 12'($urandom % 4095 + 1); err_tag_vld_i = 1'($urandom); err_tag_i = 8'($urandom);
      rx_ovf_i = ($urandom % 23) == 0; xfer_short_i = ($urandom % 23) == 0;
      xfer_long_i = ($urandom % 23) == 0; clr_err_i = ($urandom % 11) == 0;
    end
    step(); step();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule